// File: doc/BRIEF.md
# Spiking Output Layer with First-Fire Class Latch

This block is the final stage of a two-layer spiking classifier. It holds one integrate-and-fire neuron per output class, and every one of those neurons updates at the same time. Each time step, the hidden layer hands over a 36-bit spike vector with a one-cycle valid pulse. The block copies that vector into a local register bank. While this layer works through time step t-1 from the bank, the hidden layer is free to compute step t.

Each class neuron scans the banked vector one bit per clock. When a bit is set, the neuron adds its signed 16-bit weight for that hidden neuron to a 32-bit membrane voltage. Once all 36 bits have been scanned, every voltage is compared against a programmable threshold. The first class whose voltage goes above the threshold becomes the answer. From then on the result outputs are held frozen until a clear is applied.

If no class fires within a set number of time steps, the block reports completion with a no-result flag. Weights are loaded beforehand through a simple write port.

Top module: `spk_out_layer`

## Requirements
- R1: After reset, `done_o`, `nores_o` and `cls_o` are all 0.
- R2: A write with `wr_en` high stores `wr_data` as the weight from hidden neuron `wr_hid` to class `wr_cls`. Bit h of `vec_in` is the spike of hidden neuron h.
- R3: During a time step, each class voltage gains the sign-extended weight of every hidden neuron whose bit is set in the banked vector. Negative weights lower the voltage. Clear bits contribute nothing.
- R4: A class fires only if its voltage is strictly greater than the signed `thresh` at the end of a step. A voltage equal to the threshold does not fire. Voltages carry over from one step to the next.
- R5: When several classes fire in the same step, `cls_o` reports the lowest class index.
- R6: Once `done_o` is high, `done_o`, `cls_o` and `nores_o` stay unchanged, and `vec_valid` pulses have no effect, until `clr` is asserted.
- R7: A `clr` pulse zeroes all voltages, the step count, `done_o`, `nores_o` and `cls_o`.
- R8: A vector captured on a clock edge has its result on the outputs N_HID+1 edges later, and not one edge earlier.
- R9: If MAX_STEPS steps complete with no class firing, `done_o` and `nores_o` rise together and `cls_o` is 0.
- R10: A `vec_valid` pulse that arrives while a step is still being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of voltages, step count and result |
| vec_valid | input | 1 | Load strobe for the hidden spike vector |
| vec_in | input | N_HID | Hidden-layer spikes for one time step |
| wr_en | input | 1 | Weight write enable |
| wr_cls | input | CW | Class index of the weight being written |
| wr_hid | input | HW | Hidden neuron index of the weight being written |
| wr_data | input | W_W | Signed weight value |
| thresh | input | W_V | Signed firing threshold |
| done_o | output | 1 | Result is available and frozen |
| nores_o | output | 1 | Step limit reached with no class firing |
| cls_o | output | CW | Winning class index |

## Verification
Random runs load fresh weights in the range -300..700 and pick a random threshold. They then feed spike vectors of random density, step by step, until some class fires or the step limit is hit. Because these runs integrate over several steps with a mix of signs, they separate correct signed accumulation, carried-over voltage and first-fire detection from designs that reset, truncate or compare wrongly.

Directed patterns cover the remaining corners:
- Weight rows that are exactly equal, which isolate the lowest-index tie-break.
- Voltages that land exactly on the threshold, which expose a greater-or-equal comparison.
- Cancelling positive and negative weights.
- All-zero weights, which force the no-result path.
- Strobes sent mid-step or after the result, which must leave the outputs untouched.

// File: rtl/spk_out_layer.sv
module spk_out_layer #(
  parameter int N_CLASS   = 9,
  parameter int N_HID     = 36,
  parameter int W_W       = 16,
  parameter int W_V       = 32,
  parameter int MAX_STEPS = 64,
  localparam int CW = (N_CLASS > 1) ? $clog2(N_CLASS) : 1,
  localparam int HW = (N_HID > 1) ? $clog2(N_HID) : 1,
  localparam int SW = $clog2(MAX_STEPS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  vec_valid,
  input  logic [N_HID-1:0]      vec_in,
  input  logic                  wr_en,
  input  logic [CW-1:0]         wr_cls,
  input  logic [HW-1:0]         wr_hid,
  input  logic signed [W_W-1:0] wr_data,
  input  logic signed [W_V-1:0] thresh,
  output logic                  done_o,
  output logic                  nores_o,
  output logic [CW-1:0]         cls_o
);

  logic signed [W_W-1:0] wmem [N_CLASS][N_HID];
  logic [N_HID-1:0]      bank;
  logic [HW-1:0]         idx;
  logic [SW-1:0]         steps;
  logic                  busy, cmp;
  logic [N_CLASS-1:0]    fire;
  logic [CW-1:0]         first;
  logic                  hit;

  wire take = !busy && !cmp && !done_o && vec_valid;
  wire bit_on = busy && bank[idx];

  always_ff @(posedge clk)
    if (wr_en) wmem[wr_cls][wr_hid] <= wr_data;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_core
    logic signed [W_V-1:0] v;
    wire signed [W_W-1:0] w = wmem[c][idx];
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                v <= '0;
      else if (clr)              v <= '0;
      else if (bit_on)           v <= v + {{(W_V-W_W){w[W_W-1]}}, w};
      else if (cmp && fire[c])   v <= '0;
    assign fire[c] = cmp && (v > thresh);
  end

  always_comb begin
    first = '0;
    for (int i = N_CLASS - 1; i >= 0; i--)
      if (fire[i]) first = CW'(i);
  end
  assign hit = |fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bank <= '0; idx <= '0; steps <= '0;
      busy <= 1'b0; cmp <= 1'b0;
      done_o <= 1'b0; nores_o <= 1'b0; cls_o <= '0;
    end else if (clr) begin
      idx <= '0; steps <= '0;
      busy <= 1'b0; cmp <= 1'b0;
      done_o <= 1'b0; nores_o <= 1'b0; cls_o <= '0;
    end else if (take) begin
      bank <= vec_in;
      idx  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (idx == HW'(N_HID - 1)) begin
        busy <= 1'b0;
        cmp  <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end else if (cmp) begin
      cmp <= 1'b0;
      if (hit) begin
        done_o <= 1'b1;
        cls_o  <= first;
      end else begin
        steps <= steps + 1'b1;
        if (steps == SW'(MAX_STEPS - 1)) begin
          done_o  <= 1'b1;
          nores_o <= 1'b1;
        end
      end
    end

  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clr |=> done_o);
  p_cls_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !clr |=> $stable(cls_o) && $stable(nores_o));
  p_nores_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nores_o |-> done_o && cls_o == '0);
  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !clr |=> $stable(bank));
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done_o && !nores_o && steps == '0);
  p_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, cmp, done_o}));
  p_step_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    steps <= SW'(MAX_STEPS));

endmodule

// File: tb/spk_out_layer_bench.sv
`timescale 1ns/1ps
module spk_out_layer_bench;
  localparam int NC = 9, NH = 36, MS = 12;
  localparam int CW = $clog2(NC), HW = $clog2(NH);

  logic clk = 0, rst_n = 0, clr = 0, vec_valid = 0, wr_en = 0;
  logic [NH-1:0] vec_in = '0;
  logic [CW-1:0] wr_cls = '0;
  logic [HW-1:0] wr_hid = '0;
  logic signed [15:0] wr_data = '0;
  logic signed [31:0] thresh = '0;
  logic done_o, nores_o;
  logic [CW-1:0] cls_o;

  spk_out_layer #(.N_CLASS(NC), .N_HID(NH), .MAX_STEPS(MS)) u_spk_out_layer (
    .clk, .rst_n, .clr, .vec_valid, .vec_in, .wr_en, .wr_cls, .wr_hid,
    .wr_data, .thresh, .done_o, .nores_o, .cls_o);

  always #2 clk = ~clk;

  int tests = 0, fails = 0;
  int wts [NC][NH];
  int mv [NC];
  bit mdone, mnores;
  int mcls, msteps;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic void model_clear();
    for (int c = 0; c < NC; c++) mv[c] = 0;
    mdone = 0; mnores = 0; mcls = 0; msteps = 0;
  endfunction

  function automatic void model_step(logic [NH-1:0] v);
    if (mdone) return;
    for (int c = 0; c < NC; c++)
      for (int h = 0; h < NH; h++)
        if (v[h]) mv[c] += wts[c][h];
    for (int c = NC - 1; c >= 0; c--)
      if (mv[c] > int'(thresh)) begin mdone = 1; mcls = c; end
    if (!mdone) begin
      msteps++;
      if (msteps == MS) begin mdone = 1; mnores = 1; end
    end
  endfunction

  task automatic upload();
    for (int c = 0; c < NC; c++)
      for (int h = 0; h < NH; h++) begin
        @(negedge clk);
        wr_en = 1; wr_cls = CW'(c); wr_hid = HW'(h); wr_data = 16'(wts[c][h]);
      end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic zero_wts();
    for (int c = 0; c < NC; c++)
      for (int h = 0; h < NH; h++) wts[c][h] = 0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    model_clear();
  endtask

  task automatic run_step(logic [NH-1:0] v, bit chk_early, bit poke);
    @(negedge clk); vec_in = v; vec_valid = 1;
    @(negedge clk); vec_valid = 0;
    model_step(v);
    for (int i = 0; i < NH; i++) begin
      @(negedge clk);
      if (poke && i == 5) begin vec_in = '1; vec_valid = 1; end
      else vec_valid = 0;
    end
    if (chk_early) check("R8 early", int'(done_o), 0);
    @(negedge clk);
  endtask

  task automatic check_out(string req);
    check({req, " done"}, int'(done_o), int'(mdone));
    check({req, " nores"}, int'(nores_o), int'(mnores));
    if (mdone) check({req, " cls"}, int'(cls_o), mcls);
  endtask

  initial begin
    void'($urandom(32'd1234));
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 done", int'(done_o), 0);
    check("R1 nores", int'(nores_o), 0);
    check("R1 cls", int'(cls_o), 0);
    rst_n = 1;

    // R4 equal-to-threshold does not fire; integration across steps; R8 latency
    zero_wts(); wts[2][0] = 50; upload(); thresh = 100; do_clr();
    run_step(36'h1, 1, 0); check_out("R4 step1");
    run_step(36'h1, 0, 0); check_out("R4 equal");
    run_step(36'h1, 1, 0); check_out("R8 fire");
    check("R4 cls2", int'(cls_o), 2);

    // R6 frozen after done
    run_step('1, 0, 0); check_out("R6 ignore");
    check("R6 cls", int'(cls_o), 2);

    // R7 clear then R5 tie
    zero_wts(); wts[4][3] = 100; wts[7][3] = 100; upload(); thresh = 150; do_clr();
    check("R7 done", int'(done_o), 0);
    check("R7 nores", int'(nores_o), 0);
    run_step(36'h8, 0, 0); check_out("R5 step1");
    run_step(36'h8, 0, 0); check_out("R5 tie");
    check("R5 lowest", int'(cls_o), 4);

    // R3 / R2 signed cancellation, bit positions
    zero_wts(); wts[1][1] = 600; wts[1][2] = -600; wts[8][1] = 300; upload();
    thresh = 500; do_clr();
    run_step(36'h6, 0, 0); check_out("R3 step1");
    run_step(36'h6, 0, 0); check_out("R3 neg");
    check("R2 cls8", int'(cls_o), 8);

    // R10 valid during processing ignored
    zero_wts(); wts[0][35] = 40; wts[6][0] = 1000; upload(); thresh = 100; do_clr();
    run_step(36'h8_0000_0000, 0, 1); check_out("R10 poke");
    repeat (NH + 2) @(negedge clk);
    check("R10 no extra step", int'(done_o), 0);
    run_step(36'h8_0000_0000, 0, 0);
    run_step(36'h8_0000_0000, 0, 0); check_out("R10 resume");

    // R9 no result after MS steps
    zero_wts(); upload(); thresh = 0; do_clr();
    for (int s = 0; s < MS; s++) begin
      run_step(NH'({$urandom, $urandom}), 0, 0);
      check_out("R9 timeout");
    end
    check("R9 cls0", int'(cls_o), 0);

    // Random runs: R2 R3 R4 R5
    for (int t = 0; t < 20; t++) begin
      for (int c = 0; c < NC; c++)
        for (int h = 0; h < NH; h++) wts[c][h] = int'($urandom_range(1000)) - 300;
      upload();
      thresh = 32'($urandom_range(8000, 2000));
      do_clr();
      for (int s = 0; s < MS && !mdone; s++) begin
        logic [NH-1:0] v;
        for (int h = 0; h < NH; h++) v[h] = ($urandom_range(9) < 3);
        run_step(v, 0, 0);
        check_out("R3 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule